// File: doc/BRIEF.md
# Descriptor-Driven Register Capture Engine

The engine walks a list of packed descriptor words stored in a local word-addressed SRAM. Address words select a target base, and link words carry up to two run-length read bursts. Each word read in a burst is fetched over a simple request/acknowledge bus and appended to a data region of the same SRAM. The list may also contain single-register write entries, read-modify-write triples that act on the most recently addressed register, and loop-back words that repeat a section of the list a fixed number of times.

Software places a list in the SRAM and sets the list and data start words, then pulses the trigger while the engine is enabled. The status pair reads nonzero until the walk finishes. A failed bus access stops the walk and sets a sticky error flag. Software clears that flag by writing the value 3. If the capture region would run past the last SRAM word, the walk stops and the overflow flag is raised.

Top module: `llcap_engine`

## Requirements
- R1: After reset the status pair, the bus request, the SRAM request, the bus error flag and the overflow flag are all zero.
- R2: A trigger is accepted only while the enable input is high and the engine is idle. An accepted trigger starts fetching at the list start word. While the walk runs, status bit 0 is high, and status bit 1 is high while a bus transfer is pending. Both bits return to zero when the walk ends. A trigger with enable low starts nothing.
- R3: Bits [31:30] of a descriptor give its kind: 00 is an address word, 01 is a loop word, 10 is a read-modify-write marker, 11 is a link word. A link word equal to 0xC000_0000 ends the walk.
- R4: In an address word, the bus base is bits [27:0] shifted left by 4. Bit 28 set marks a write entry. Bit 29 drives the bus APB-select output (1 = APB, 0 = AHB) for the transfers that follow.
- R5: A link word holds pair 0 in bits [14:0] (word delta in [7:0], length in [14:8]) and pair 1 in bits [29:15] (delta in [22:15], length in [29:23]). A pair is active when its length is nonzero. Each pair starts at word offset run + delta, and run then becomes start + length - 1. Run resets to zero at every address word. Each word read is at base + 4 × offset.
- R6: Words read in bursts are stored in order into consecutive SRAM words, starting at the data start word.
- R7: A write entry is an address word with bit 28 set, a link word whose pair 0 delta is the word offset, and a data word. The engine issues one bus write of that data to base + 4 × delta.
- R8: A read-modify-write marker is followed by a mask word and a value word. The engine reads the last bus address and writes back (old & ~mask) | (value & mask).
- R9: A loop word has a step field in bits [LOOP_LSB-1:0] and a count field in bits [27:LOOP_LSB]. The section that starts step words before the loop word runs count + 1 times in total. A count of zero falls straight through.
- R10: A bus error response stops the walk, stores nothing, and sets the bus error flag. The flag holds until an error-register write with value 2'b11. A write of any other value has no effect.
- R11: When the next capture would be stored past the last SRAM word, the walk stops with the overflow flag set and nothing more is stored. The flag clears on the next accepted trigger.
- R12: Once raised, a bus request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Engine enable |
| trigger_i | input | 1 | Start a walk |
| list_base_i | input | AW | SRAM word where the list starts |
| data_base_i | input | AW | SRAM word where captures start |
| err_wr_i | input | 1 | Write strobe for the error register |
| err_wdata_i | input | 2 | Error register write value; 2'b11 clears |
| sram_req_o | output | 1 | SRAM access request |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | AW | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, one cycle after request |
| bus_req_o | output | 1 | Target bus request |
| bus_we_o | output | 1 | Target bus write |
| bus_apb_o | output | 1 | Bus select: 1 = APB, 0 = AHB |
| bus_addr_o | output | 32 | Target byte address |
| bus_wdata_o | output | 32 | Target write data |
| bus_ack_i | input | 1 | Target acknowledge |
| bus_err_i | input | 1 | Error response, valid with acknowledge |
| bus_rdata_i | input | 32 | Target read data, valid with acknowledge |
| status_o | output | 2 | Busy pair; both zero means ready |
| bus_err_o | output | 1 | Sticky bus error flag |
| ovf_o | output | 1 | Capture region overflow flag |

## Verification
The hardest states to reach are the ones that depend on walk history. Examples are the second pass through a loop, a second pair that reuses the run left by the first, and a read-modify-write that must target an address issued earlier. The bench reaches them by placing hand-built lists in its SRAM model, with loop steps that jump back onto an address word. Its target model returns each register's address until that register is written, so the expected result of every capture, loop repeat and merged write can be computed in advance. Overflow is reached by placing the data start two words before the end of the SRAM and asking for a four-word burst.

// File: rtl/llcap_pkg.sv
`timescale 1ns/1ps
package llcap_pkg;
  typedef enum logic [1:0] {
    K_ADDR = 2'b00,
    K_LOOP = 2'b01,
    K_RMW  = 2'b10,
    K_LINK = 2'b11
  } kind_e;

  localparam logic [31:0] TERM_WORD = 32'hC000_0000;

  typedef struct packed {
    logic [6:0] len;
    logic [7:0] delta;
  } pair_t;

  typedef enum logic [1:0] {F_DESC, F_WDATA, F_MASK, F_VAL} fetch_e;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_RMW_RD, OP_RMW_WR} op_e;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DEC, S_BUS, S_STORE} state_e;
endpackage

// File: rtl/llcap_desc_dec.sv
`timescale 1ns/1ps
module llcap_desc_dec
  import llcap_pkg::*;
#(
  parameter int LOOP_LSB = 13,
  localparam int REPW = 28 - LOOP_LSB
) (
  input  logic [31:0]         word_i,
  output kind_e               kind_o,
  output logic [31:0]         base_o,
  output logic                wr_o,
  output logic                apb_o,
  output pair_t               p0_o,
  output pair_t               p1_o,
  output logic                term_o,
  output logic [LOOP_LSB-1:0] step_o,
  output logic [REPW-1:0]     rep_o
);
  assign kind_o = kind_e'(word_i[31:30]);
  assign base_o = {word_i[27:0], 4'h0};
  assign wr_o   = word_i[28];
  assign apb_o  = word_i[29];
  assign p0_o   = word_i[14:0];
  assign p1_o   = word_i[29:15];
  assign term_o = (word_i == TERM_WORD);
  assign step_o = word_i[LOOP_LSB-1:0];
  assign rep_o  = word_i[27:LOOP_LSB];
endmodule

// File: rtl/llcap_loop_ctr.sv
`timescale 1ns/1ps
module llcap_loop_ctr #(
  parameter int REPW = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            hit_i,
  input  logic [REPW-1:0] rep_i,
  output logic            jump_o
);
  logic            active_q;
  logic [REPW-1:0] rem_q;

  // rem_q: repeats still owed once the loop is live
  assign jump_o = active_q ? (rem_q != REPW'(1)) : (rep_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
    end else if (hit_i) begin
      if (!active_q) begin
        if (rep_i != '0) begin
          active_q <= 1'b1;
          rem_q    <= rep_i;
        end
      end else if (rem_q == REPW'(1)) begin
        active_q <= 1'b0;
      end else begin
        rem_q <= rem_q - REPW'(1);
      end
    end
  end

  assert_loop_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !clr_i && active_q && rem_q != REPW'(1)) |=>
      (active_q && rem_q == $past(rem_q) - REPW'(1)));

  assert_loop_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !active_q && rep_i == '0) |-> !jump_o);
endmodule

// File: rtl/llcap_err_latch.sv
`timescale 1ns/1ps
module llcap_err_latch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          err_o <= 1'b0;
    else if (set_i)                       err_o <= 1'b1;
    else if (wr_i && wdata_i == 2'b11)    err_o <= 1'b0;
  end

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == 2'b11 && !set_i) |=> !err_o);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(wr_i && wdata_i == 2'b11)) |=> err_o);
endmodule

// File: rtl/llcap_engine.sv
`timescale 1ns/1ps
module llcap_engine
  import llcap_pkg::*;
#(
  parameter int AW       = 8,
  parameter int LOOP_LSB = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          trigger_i,
  input  logic [AW-1:0] list_base_i,
  input  logic [AW-1:0] data_base_i,
  input  logic          err_wr_i,
  input  logic [1:0]    err_wdata_i,
  output logic          sram_req_o,
  output logic          sram_we_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [31:0]   sram_wdata_o,
  input  logic [31:0]   sram_rdata_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_apb_o,
  output logic [31:0]   bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  input  logic [31:0]   bus_rdata_i,
  output logic [1:0]    status_o,
  output logic          bus_err_o,
  output logic          ovf_o
);
  localparam int REPW = 28 - LOOP_LSB;
  localparam int OFFW = 16;

  state_e         state_q;
  fetch_e         fk_q;
  op_e            op_q;
  logic [AW-1:0]  ptr_q;
  logic [AW:0]    dptr_q;
  logic [31:0]    base_q, addr_q, wdata_q, mask_q, val_q, cap_q;
  logic           apb_q, wmode_q, p1_pend_q, ovf_q;
  pair_t          p1_q;
  logic [OFFW-1:0] run_q;
  logic [6:0]     rem_q;

  kind_e               dec_kind;
  logic [31:0]         dec_base;
  logic                dec_wr, dec_apb, dec_term;
  pair_t               dec_p0, dec_p1;
  logic [LOOP_LSB-1:0] dec_step;
  logic [REPW-1:0]     dec_rep;

  llcap_desc_dec #(.LOOP_LSB(LOOP_LSB)) u_dec (
    .word_i (sram_rdata_i),
    .kind_o (dec_kind),
    .base_o (dec_base),
    .wr_o   (dec_wr),
    .apb_o  (dec_apb),
    .p0_o   (dec_p0),
    .p1_o   (dec_p1),
    .term_o (dec_term),
    .step_o (dec_step),
    .rep_o  (dec_rep)
  );

  logic start_ok, desc_dec, loop_hit, loop_jump, bus_fail;
  assign start_ok = (state_q == S_IDLE) && enable_i && trigger_i;
  assign desc_dec = (state_q == S_DEC) && (fk_q == F_DESC);
  assign loop_hit = desc_dec && (dec_kind == K_LOOP);
  assign bus_fail = (state_q == S_BUS) && bus_ack_i && bus_err_i;

  llcap_loop_ctr #(.REPW(REPW)) u_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .hit_i  (loop_hit),
    .rep_i  (dec_rep),
    .jump_o (loop_jump)
  );

  llcap_err_latch u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (bus_fail),
    .wr_i    (err_wr_i),
    .wdata_i (err_wdata_i),
    .err_o   (bus_err_o)
  );

  // pair being started: from the fresh link word in DEC, else the saved second pair
  pair_t           sel_pair;
  logic [OFFW-1:0] start_abs, run_end;
  logic [31:0]     start_addr;
  always_comb begin
    if (state_q == S_DEC) sel_pair = (dec_p0.len != '0) ? dec_p0 : dec_p1;
    else                  sel_pair = p1_q;
    start_abs  = run_q + OFFW'(sel_pair.delta);
    run_end    = start_abs + OFFW'(sel_pair.len) - OFFW'(1);
    start_addr = base_q + 32'({start_abs, 2'b00});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      fk_q      <= F_DESC;
      op_q      <= OP_RD;
      ptr_q     <= '0;
      dptr_q    <= '0;
      base_q    <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      val_q     <= '0;
      cap_q     <= '0;
      apb_q     <= 1'b0;
      wmode_q   <= 1'b0;
      p1_pend_q <= 1'b0;
      ovf_q     <= 1'b0;
      p1_q      <= '0;
      run_q     <= '0;
      rem_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_ok) begin
          state_q   <= S_FETCH;
          fk_q      <= F_DESC;
          ptr_q     <= list_base_i;
          dptr_q    <= {1'b0, data_base_i};
          ovf_q     <= 1'b0;
          run_q     <= '0;
          wmode_q   <= 1'b0;
          apb_q     <= 1'b0;
          base_q    <= '0;
          p1_pend_q <= 1'b0;
        end
        S_FETCH: state_q <= S_DEC;
        S_DEC: begin
          ptr_q   <= ptr_q + AW'(1);
          state_q <= S_FETCH;
          case (fk_q)
            F_WDATA: begin
              wdata_q <= sram_rdata_i;
              op_q    <= OP_WR;
              fk_q    <= F_DESC;
              state_q <= S_BUS;
            end
            F_MASK: begin
              mask_q <= sram_rdata_i;
              fk_q   <= F_VAL;
            end
            F_VAL: begin
              val_q   <= sram_rdata_i;
              op_q    <= OP_RMW_RD;
              fk_q    <= F_DESC;
              state_q <= S_BUS;
            end
            default: begin
              case (dec_kind)
                K_ADDR: begin
                  base_q  <= dec_base;
                  wmode_q <= dec_wr;
                  apb_q   <= dec_apb;
                  run_q   <= '0;
                end
                K_RMW:  fk_q <= F_MASK;
                K_LOOP: if (loop_jump) ptr_q <= ptr_q - AW'(dec_step);
                default: begin
                  if (dec_term) begin
                    state_q <= S_IDLE;
                  end else if (wmode_q) begin
                    addr_q  <= start_addr;
                    wmode_q <= 1'b0;
                    fk_q    <= F_WDATA;
                  end else if (sel_pair.len != '0) begin
                    addr_q    <= start_addr;
                    rem_q     <= sel_pair.len;
                    run_q     <= run_end;
                    p1_q      <= dec_p1;
                    p1_pend_q <= (dec_p0.len != '0) && (dec_p1.len != '0);
                    op_q      <= OP_RD;
                    state_q   <= S_BUS;
                  end
                end
              endcase
            end
          endcase
        end
        S_BUS: if (bus_ack_i) begin
          if (bus_err_i) begin
            state_q <= S_IDLE;
          end else begin
            case (op_q)
              OP_RD: begin
                cap_q   <= bus_rdata_i;
                state_q <= S_STORE;
              end
              OP_RMW_RD: begin
                wdata_q <= (bus_rdata_i & ~mask_q) | (val_q & mask_q);
                op_q    <= OP_RMW_WR;
              end
              default: state_q <= S_FETCH;
            endcase
          end
        end
        S_STORE: begin
          if (dptr_q[AW]) begin
            ovf_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            dptr_q <= dptr_q + (AW+1)'(1);
            if (rem_q != 7'd1) begin
              rem_q   <= rem_q - 7'd1;
              addr_q  <= addr_q + 32'd4;
              state_q <= S_BUS;
            end else if (p1_pend_q) begin
              p1_pend_q <= 1'b0;
              addr_q    <= start_addr;
              rem_q     <= p1_q.len;
              run_q     <= run_end;
              state_q   <= S_BUS;
            end else begin
              state_q <= S_FETCH;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sram_we_o    = (state_q == S_STORE) && !dptr_q[AW];
  assign sram_req_o   = (state_q == S_FETCH) || sram_we_o;
  assign sram_addr_o  = (state_q == S_STORE) ? dptr_q[AW-1:0] : ptr_q;
  assign sram_wdata_o = cap_q;
  assign bus_req_o    = (state_q == S_BUS);
  assign bus_we_o     = (op_q == OP_WR) || (op_q == OP_RMW_WR);
  assign bus_apb_o    = apb_q;
  assign bus_addr_o   = addr_q;
  assign bus_wdata_o  = wdata_q;
  assign status_o     = {state_q == S_BUS, state_q != S_IDLE};
  assign ovf_o        = ovf_q;

  assert_bus_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

  assert_no_store_after_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !sram_we_o);

  assert_req_needs_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o || bus_req_o) |-> status_o[0]);
endmodule

// File: tb/llcap_engine_tb.sv
`timescale 1ns/1ps
module llcap_engine_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] TERM = 32'hC000_0000;
  localparam logic [7:0] DB = 8'h80;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  // {base field[37:30], d0[29:22], l0[21:15], d1[14:7], l1[6:0]}
  localparam logic [37:0] VEC [4] = '{
    {8'h10, 8'd2, 7'd3, 8'd0, 7'd0},
    {8'h20, 8'd0, 7'd1, 8'd3, 7'd2},
    {8'h35, 8'd5, 7'd2, 8'd1, 7'd4},
    {8'h01, 8'd0, 7'd4, 8'd0, 7'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, trig = 1'b0, err_wr = 1'b0;
  logic [1:0] err_wd = 2'b00;
  logic [AW-1:0] lb = '0, db = DB;
  logic sram_req, sram_we;
  logic [AW-1:0] sram_addr;
  logic [31:0] sram_wdata, sram_rdata = '0;
  logic bus_req, bus_we, bus_apb;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic bus_ack = 1'b0, bus_err = 1'b0;
  logic [1:0] status;
  logic err_flag, ovf;

  logic [31:0] mem [DEPTH];
  logic [31:0] tgt [64];
  logic tb_wr = 1'b0, tgt_clr = 1'b0;
  logic [AW-1:0] tb_a = '0;
  logic [31:0] tb_d = '0;
  int total = 0, fails = 0, viol = 0, wait_cnt = 0;
  logic lat = 1'b0, prev_hold = 1'b0, last_apb = 1'b0, done = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2 clk = ~clk;

  llcap_engine #(.AW(AW), .LOOP_LSB(13)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .trigger_i(trig),
    .list_base_i(lb), .data_base_i(db), .err_wr_i(err_wr), .err_wdata_i(err_wd),
    .sram_req_o(sram_req), .sram_we_o(sram_we), .sram_addr_o(sram_addr),
    .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_apb_o(bus_apb),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack),
    .bus_err_i(bus_err), .bus_rdata_i(bus_rdata),
    .status_o(status), .bus_err_o(err_flag), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    if (tb_wr) mem[tb_a] <= tb_d;
    else if (sram_req && sram_we) mem[sram_addr] <= sram_wdata;
    if (sram_req && !sram_we) sram_rdata <= mem[sram_addr];
  end

  // target model: a register reads back its address until written
  always @(negedge clk) begin
    if (tgt_clr) for (int i = 0; i < 64; i++) tgt[i] = '0;
    if (bus_ack) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
    end else if (bus_req) begin
      if (prev_hold && bus_addr != prev_addr) viol++;
      if (wait_cnt < int'(lat)) wait_cnt++;
      else begin
        wait_cnt = 0;
        lat = ~lat;
        bus_ack = 1'b1;
        bus_err = (bus_addr[31:28] == 4'hE);
        if (bus_we) tgt[bus_addr[7:2]] = bus_wdata ^ bus_addr;
        bus_rdata = tgt[bus_addr[7:2]] ^ bus_addr;
        last_apb = bus_apb;
      end
    end
    prev_hold = bus_req && !bus_ack;
    prev_addr = bus_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    tb_wr = 1'b1; tb_a = a; tb_d = d;
    @(posedge clk); #1;
    tb_wr = 1'b0;
  endtask

  task automatic prep();
    for (int i = 0; i < 8; i++) poke(DB + AW'(i), SENT);
    @(posedge clk); #1 tgt_clr = 1'b1;
    @(posedge clk); #1 tgt_clr = 1'b0;
  endtask

  function automatic logic [31:0] w_addr(input logic [27:0] f, input logic wr, input logic apb);
    return {2'b00, apb, wr, f};
  endfunction
  function automatic logic [31:0] w_link(input logic [7:0] d0, input logic [6:0] l0,
                                         input logic [7:0] d1, input logic [6:0] l1);
    if (l1 == '0) return 32'hC000_8000 | {17'd0, l0, d0};
    return 32'hC000_0000 | {2'b00, l1, d1, l0, d0};
  endfunction
  function automatic logic [31:0] w_loop(input logic [12:0] step, input logic [14:0] cnt);
    return 32'h4000_0000 | {4'h0, cnt, step};
  endfunction

  task automatic walk(input logic [AW-1:0] dbase);
    int n;
    @(posedge clk); #1;
    lb = '0; db = dbase; en = 1'b1; trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
    @(negedge clk);
    chk("R2 busy during walk", {31'd0, status[0]}, 32'd1);
    n = 0;
    while (status != 2'b00 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk("R2 walk timeout", 32'd1, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, a;
    int k, abs_o, run;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) tgt[i] = '0;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {30'd0, status}, 32'd0);
    chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
    chk("R1 sram_req", {31'd0, sram_req}, 32'd0);
    chk("R1 err", {31'd0, err_flag}, 32'd0);
    chk("R1 ovf", {31'd0, ovf}, 32'd0);

    // R2: trigger ignored while disabled
    prep();
    poke(0, w_addr(28'h10, 1'b0, 1'b0)); poke(1, w_link(0, 1, 0, 0)); poke(2, TERM);
    @(posedge clk); #1 en = 1'b0; trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 disabled status", {30'd0, status}, 32'd0);
    chk("R2 disabled no capture", mem[DB], SENT);

    // table: R3 R5 R6 single link words with one or two pairs
    for (int v = 0; v < 4; v++) begin
      prep();
      poke(0, w_addr({20'd0, VEC[v][37:30]}, 1'b0, 1'b0));
      poke(1, w_link(VEC[v][29:22], VEC[v][21:15], VEC[v][14:7], VEC[v][6:0]));
      poke(2, TERM);
      walk(DB);
      base = {20'd0, VEC[v][37:30], 4'h0};
      k = 0;
      abs_o = int'(VEC[v][29:22]);
      for (int i = 0; i < int'(VEC[v][21:15]); i++) begin
        chk("R5 R6 pair0 capture", mem[DB + AW'(k)], base + 32'(4 * (abs_o + i))); k++;
      end
      run = abs_o + int'(VEC[v][21:15]) - 1;
      abs_o = run + int'(VEC[v][14:7]);
      for (int i = 0; i < int'(VEC[v][6:0]); i++) begin
        chk("R5 R6 pair1 capture", mem[DB + AW'(k)], base + 32'(4 * (abs_o + i))); k++;
      end
      chk("R6 no extra store", mem[DB + AW'(k)], SENT);
      chk("R3 terminator ends walk", {30'd0, status}, 32'd0);
      chk("R4 AHB select", {31'd0, last_apb}, 32'd0);
    end

    // R5 R4: new address word resets run, APB flag follows
    prep();
    poke(0, w_addr(28'h70, 1'b0, 1'b0)); poke(1, w_link(4, 1, 0, 0));
    poke(2, w_addr(28'h71, 1'b0, 1'b1)); poke(3, w_link(1, 1, 0, 0)); poke(4, TERM);
    walk(DB);
    chk("R5 first group", mem[DB], 32'h710);
    chk("R5 run reset at address word", mem[DB + 1], 32'h714);
    chk("R4 APB select", {31'd0, last_apb}, 32'd1);

    // R7: write entry then read back
    prep();
    poke(0, w_addr(28'h40, 1'b1, 1'b0)); poke(1, w_link(3, 1, 0, 0)); poke(2, 32'h1234_5678);
    poke(3, w_addr(28'h40, 1'b0, 1'b0)); poke(4, w_link(3, 1, 0, 0)); poke(5, TERM);
    walk(DB);
    chk("R7 written value read back", mem[DB], 32'h1234_5678);
    chk("R7 write stores nothing", mem[DB + 1], SENT);

    // R8: read-modify-write on last address
    prep();
    poke(0, w_addr(28'h50, 1'b0, 1'b0)); poke(1, w_link(2, 1, 0, 0));
    poke(2, 32'h8000_0000); poke(3, 32'h0000_FF00); poke(4, 32'h0000_AB00);
    poke(5, w_addr(28'h50, 1'b0, 1'b0)); poke(6, w_link(2, 1, 0, 0)); poke(7, TERM);
    walk(DB);
    chk("R8 capture before merge", mem[DB], 32'h508);
    chk("R8 merged value", mem[DB + 1], 32'hAB08);

    // R9: loop with count 2 runs three times
    prep();
    poke(0, w_addr(28'h60, 1'b0, 1'b0)); poke(1, w_link(0, 1, 0, 0));
    poke(2, w_loop(2, 2)); poke(3, TERM);
    walk(DB);
    for (int i = 0; i < 3; i++) chk("R9 loop capture", mem[DB + AW'(i)], 32'h600);
    chk("R9 loop exits", mem[DB + 3], SENT);

    // R9: count zero falls through
    prep();
    poke(2, w_loop(2, 0));
    walk(DB);
    chk("R9 zero count single pass", mem[DB], 32'h600);
    chk("R9 zero count no repeat", mem[DB + 1], SENT);

    // R10: bus error stops, sticky until value 3
    prep();
    poke(0, w_addr(28'h0E00_0000, 1'b0, 1'b0)); poke(1, w_link(0, 2, 0, 0)); poke(2, TERM);
    walk(DB);
    chk("R10 error flag", {31'd0, err_flag}, 32'd1);
    chk("R10 nothing stored", mem[DB], SENT);
    @(posedge clk); #1 err_wr = 1'b1; err_wd = 2'b01;
    @(posedge clk); #1 err_wr = 1'b0;
    @(negedge clk);
    chk("R10 other value ignored", {31'd0, err_flag}, 32'd1);
    @(posedge clk); #1 err_wr = 1'b1; err_wd = 2'b11;
    @(posedge clk); #1 err_wr = 1'b0;
    @(negedge clk);
    chk("R10 cleared by 3", {31'd0, err_flag}, 32'd0);

    // R11: overflow at end of SRAM
    prep();
    poke(0, w_addr(28'h10, 1'b0, 1'b0)); poke(1, w_link(0, 4, 0, 0)); poke(2, TERM);
    poke(AW'(DEPTH - 2), SENT); poke(AW'(DEPTH - 1), SENT);
    walk(AW'(DEPTH - 2));
    chk("R11 overflow flag", {31'd0, ovf}, 32'd1);
    chk("R11 last words stored", mem[DEPTH - 2], 32'h100);
    chk("R11 last words stored", mem[DEPTH - 1], 32'h104);
    chk("R11 stopped", {30'd0, status}, 32'd0);
    walk(DB);
    chk("R11 cleared on trigger", {31'd0, ovf}, 32'd0);
    a = mem[DB + 3];
    chk("R11 normal walk after", a, 32'h10C);

    chk("R12 request held until ack", 32'(viol), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule